// File: doc/BRIEF.md
# Event-Driven Timer Control Unit

This block runs a single up/down counter whose every action is triggered by hardware events rather than by software. Fourteen raw lines feed it: four external trigger inputs, two I/O pins (A and B) and eight internal event lines. All of them are synchronized and turned into a vector of 24 single-cycle event strobes. The strobes cover both edges of each trigger, each pin edge qualified by the level of the other pin, and rising edges of the internal lines.

Seven independent 24-bit masks, driven as plain input ports, select which strobes start the counter, stop it, clear it, capture it into register A or register B, step it up by one, or step it down by one. Any set of sources can be combined for one action. Setting the up and down masks to pin-edge conditions turns the block into a quadrature decoder. If both step masks are zero, the counter instead advances by one on every clock while it runs.

Top module: `evt_timer_ctrl`

## Requirements
- R1: After reset the counter is 0, the counter is stopped, both capture registers are 0 and both capture flags are low.
- R2: A selected start strobe makes the counter run and a selected stop strobe halts it. When start and stop strike in the same cycle, stop wins.
- R3: A selected clear strobe sets the counter to 0, and it overrides any counting in that same cycle.
- R4: While running with both step masks zero, the counter rises by one every clock and wraps from its all-ones value to 0.
- R5: With a non-zero step mask, the counter moves only while running: +1 on an up strobe, -1 on a down strobe, and no change when both strike in the same cycle or when it is stopped.
- R6: A selected capture strobe loads the counter value from before that cycle's update into capture register A or B, and raises the matching flag for exactly one cycle.
- R7: Event bits 0..7 carry external triggers 0..3, with trigger k rising on bit 2k and falling on bit 2k+1.
- R8: Event bits 8..11 are pin-A edges qualified by the level of pin B: bit 8 is A rising with B low, bit 9 is A rising with B high, bit 10 is A falling with B low, and bit 11 is A falling with B high.
- R9: Event bits 12..15 use the same four conditions for pin-B edges, qualified by the level of pin A.
- R10: Event bits 16..23 are rising edges of internal lines 0..7. A falling internal line produces no event.
- R11: Every input passes through a two-stage synchronizer. A change on an input affects the outputs after the third rising clock edge and not before.
- R12: A strobe whose bit is clear in every mask changes neither the counter nor the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_trig_i | input | 4 | External trigger lines |
| pin_a_i | input | 1 | I/O pin A input level |
| pin_b_i | input | 1 | I/O pin B input level |
| int_evt_i | input | 8 | Internal event lines |
| start_mask_i | input | 24 | Sources that start the counter |
| stop_mask_i | input | 24 | Sources that stop the counter |
| clear_mask_i | input | 24 | Sources that clear the counter |
| cap_a_mask_i | input | 24 | Sources that capture into register A |
| cap_b_mask_i | input | 24 | Sources that capture into register B |
| up_mask_i | input | 24 | Sources that step the counter up |
| down_mask_i | input | 24 | Sources that step the counter down |
| count_o | output | CNT_W | Counter value |
| running_o | output | 1 | Counter run state |
| cap_a_o | output | CNT_W | Capture register A |
| cap_b_o | output | CNT_W | Capture register B |
| cap_a_flag_o | output | 1 | One-cycle strobe on capture A |
| cap_b_flag_o | output | 1 | One-cycle strobe on capture B |

## Verification
The counting function is exercised in three ways. First, it free-runs on the clock, which shows that clock fallback is chosen only when both step masks are empty, and that the counter wraps. Second, a full forward and then reverse quadrature sequence on pins A and B exercises each of the eight qualified pin conditions, so a swapped qualifier or a swapped edge polarity shows up as a wrong step direction. Third, internal-line pulses are applied singly and in pairs, which separates single steps from same-cycle cancellation and from steps taken while stopped. Stimulus on unmasked bits, and a start strobe that coincides with a stop strobe, check priority and isolation. A sample taken one cycle early pins down the synchronizer depth.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
    localparam int N_EXT   = 4;
    localparam int N_QUAL  = 8;
    localparam int N_INT   = 8;
    localparam int N_EVT   = 2 * N_EXT + N_QUAL + N_INT;
    localparam int N_RAW   = N_EXT + 2 + N_INT;
    // positions in the raw (synchronized) input vector
    localparam int RAW_PA  = N_EXT;
    localparam int RAW_PB  = N_EXT + 1;
    localparam int RAW_INT = N_EXT + 2;
    // positions in the event vector
    localparam int EV_PA   = 2 * N_EXT;
    localparam int EV_PB   = EV_PA + 4;
    localparam int EV_INT  = EV_PA + N_QUAL;

    typedef logic [N_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = raw_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/evt_decode.sv
module evt_decode
    import evt_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_RAW-1:0] cur_i,
    input  logic [N_RAW-1:0] prev_i,
    output evt_vec_t         evt_o
);
    logic a_rise, a_fall, b_rise, b_fall, a_lvl, b_lvl;

    always_comb begin
        a_rise = cur_i[RAW_PA] & ~prev_i[RAW_PA];
        a_fall = ~cur_i[RAW_PA] & prev_i[RAW_PA];
        b_rise = cur_i[RAW_PB] & ~prev_i[RAW_PB];
        b_fall = ~cur_i[RAW_PB] & prev_i[RAW_PB];
        // qualifying level is the previous sample of the other pin
        a_lvl  = prev_i[RAW_PA];
        b_lvl  = prev_i[RAW_PB];
    end

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        assign evt_o[2*k]   = cur_i[k] & ~prev_i[k];
        assign evt_o[2*k+1] = ~cur_i[k] & prev_i[k];
    end

    assign evt_o[EV_PA+0] = a_rise & ~b_lvl;
    assign evt_o[EV_PA+1] = a_rise &  b_lvl;
    assign evt_o[EV_PA+2] = a_fall & ~b_lvl;
    assign evt_o[EV_PA+3] = a_fall &  b_lvl;
    assign evt_o[EV_PB+0] = b_rise & ~a_lvl;
    assign evt_o[EV_PB+1] = b_rise &  a_lvl;
    assign evt_o[EV_PB+2] = b_fall & ~a_lvl;
    assign evt_o[EV_PB+3] = b_fall &  a_lvl;

    for (genvar k = 0; k < N_INT; k++) begin : g_int
        assign evt_o[EV_INT+k] = cur_i[RAW_INT+k] & ~prev_i[RAW_INT+k];
    end

    // R8: the four pin-A conditions exclude one another
    a_r8_pin_a_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o[EV_PA+3:EV_PA]));
    // R9: the four pin-B conditions exclude one another
    a_r9_pin_b_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o[EV_PB+3:EV_PB]));
endmodule

// File: rtl/evt_core.sv
module evt_core
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  evt_vec_t         evt_i,
    input  evt_vec_t         start_mask_i,
    input  evt_vec_t         stop_mask_i,
    input  evt_vec_t         clear_mask_i,
    input  evt_vec_t         cap_a_mask_i,
    input  evt_vec_t         cap_b_mask_i,
    input  evt_vec_t         up_mask_i,
    input  evt_vec_t         down_mask_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic [CNT_W-1:0] cap_a_o,
    output logic [CNT_W-1:0] cap_b_o,
    output logic             cap_a_flag_o,
    output logic             cap_b_flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap_a;
        logic [CNT_W-1:0] cap_b;
        logic             run;
        logic             flag_a;
        logic             flag_b;
    } core_t;

    core_t st_d, st_q;
    logic  start_hit, stop_hit, clr_hit, capa_hit, capb_hit, up_hit, dn_hit;
    logic  clk_mode;

    always_comb begin
        start_hit = |(evt_i & start_mask_i);
        stop_hit  = |(evt_i & stop_mask_i);
        clr_hit   = |(evt_i & clear_mask_i);
        capa_hit  = |(evt_i & cap_a_mask_i);
        capb_hit  = |(evt_i & cap_b_mask_i);
        up_hit    = |(evt_i & up_mask_i);
        dn_hit    = |(evt_i & down_mask_i);
        clk_mode  = (up_mask_i == '0) && (down_mask_i == '0);

        st_d        = st_q;
        st_d.flag_a = 1'b0;
        st_d.flag_b = 1'b0;
        if (capa_hit) begin
            st_d.cap_a  = st_q.cnt;
            st_d.flag_a = 1'b1;
        end
        if (capb_hit) begin
            st_d.cap_b  = st_q.cnt;
            st_d.flag_b = 1'b1;
        end
        if (st_q.run) begin
            if (clk_mode)               st_d.cnt = st_q.cnt + 1'b1;
            else if (up_hit && !dn_hit) st_d.cnt = st_q.cnt + 1'b1;
            else if (dn_hit && !up_hit) st_d.cnt = st_q.cnt - 1'b1;
        end
        if (clr_hit)        st_d.cnt = '0;
        if (stop_hit)       st_d.run = 1'b0;
        else if (start_hit) st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o      = st_q.cnt;
    assign running_o    = st_q.run;
    assign cap_a_o      = st_q.cap_a;
    assign cap_b_o      = st_q.cap_b;
    assign cap_a_flag_o = st_q.flag_a;
    assign cap_b_flag_o = st_q.flag_b;

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (count_o == '0));
    a_r2_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !running_o);
    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_hit && !stop_hit) |=> running_o);
    a_r6_cap_a_value: assert property (@(posedge clk) disable iff (!rst_n)
        capa_hit |=> (cap_a_flag_o && cap_a_o == $past(count_o)));
    a_r6_cap_b_value: assert property (@(posedge clk) disable iff (!rst_n)
        capb_hit |=> (cap_b_flag_o && cap_b_o == $past(count_o)));
    a_r4_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && clk_mode && !clr_hit) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));
    a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_mode && up_hit && dn_hit && !clr_hit) |=> $stable(count_o));
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !clr_hit) |=> $stable(count_o));
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ext_trig_i,
    input  logic             pin_a_i,
    input  logic             pin_b_i,
    input  logic [7:0]       int_evt_i,
    input  logic [23:0]      start_mask_i,
    input  logic [23:0]      stop_mask_i,
    input  logic [23:0]      clear_mask_i,
    input  logic [23:0]      cap_a_mask_i,
    input  logic [23:0]      cap_b_mask_i,
    input  logic [23:0]      up_mask_i,
    input  logic [23:0]      down_mask_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic [CNT_W-1:0] cap_a_o,
    output logic [CNT_W-1:0] cap_b_o,
    output logic             cap_a_flag_o,
    output logic             cap_b_flag_o
);
    logic [N_RAW-1:0] raw, cur, prev;
    evt_vec_t         evt;

    assign raw = {int_evt_i, pin_b_i, pin_a_i, ext_trig_i};

    evt_sync #(.W(N_RAW)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .cur_o(cur), .prev_o(prev)
    );

    evt_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev), .evt_o(evt)
    );

    evt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .start_mask_i(start_mask_i), .stop_mask_i(stop_mask_i),
        .clear_mask_i(clear_mask_i), .cap_a_mask_i(cap_a_mask_i),
        .cap_b_mask_i(cap_b_mask_i), .up_mask_i(up_mask_i),
        .down_mask_i(down_mask_i),
        .count_o(count_o), .running_o(running_o),
        .cap_a_o(cap_a_o), .cap_b_o(cap_b_o),
        .cap_a_flag_o(cap_a_flag_o), .cap_b_flag_o(cap_b_flag_o)
    );
endmodule

// File: tb/evt_timer_ctrl_tb.sv
module evt_timer_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ext_trig = '0;
    logic          pin_a = 1'b0, pin_b = 1'b0;
    logic [7:0]    int_evt = '0;
    logic [23:0]   m_start = '0, m_stop = '0, m_clr = '0, m_ca = '0, m_cb = '0, m_up = '0, m_dn = '0;
    logic [CW-1:0] count, cap_a, cap_b;
    logic          running, fa, fb;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer_ctrl #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_trig_i(ext_trig), .pin_a_i(pin_a), .pin_b_i(pin_b),
        .int_evt_i(int_evt), .start_mask_i(m_start), .stop_mask_i(m_stop),
        .clear_mask_i(m_clr), .cap_a_mask_i(m_ca), .cap_b_mask_i(m_cb),
        .up_mask_i(m_up), .down_mask_i(m_dn), .count_o(count), .running_o(running),
        .cap_a_o(cap_a), .cap_b_o(cap_b), .cap_a_flag_o(fa), .cap_b_flag_o(fb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // wait until a change driven at a falling edge has reached the outputs
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 running", running, 0);
        chk("R1 cap_a", cap_a, 0);
        chk("R1 cap_b", cap_b, 0);
        chk("R1 flags", {fa, fb}, 0);
    endtask

    task automatic t_ignored();
        m_start = 24'h1; m_stop = 24'h2; m_clr = 24'h10;
        ext_trig[3] = 1'b1;               // bit 6, in no mask
        settle();
        chk("R12 run after unmasked", running, 0);
        chk("R12 count after unmasked", count, 0);
        ext_trig[3] = 1'b0;
        settle();
    endtask

    task automatic t_start_latency();
        ext_trig[0] = 1'b1;               // bit 0 rising -> start
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet running", running, 0);
        cycles(1);
        chk("R7 R2 running", running, 1);
        chk("R4 count at start", count, 0);
        cycles(5);
        chk("R4 free count", count, 5);
    endtask

    task automatic t_clear_running();
        ext_trig[2] = 1'b1;               // bit 4 rising -> clear
        settle();
        chk("R3 clear overrides count", count, 0);
        cycles(1);
        chk("R3 count after clear", count, 1);
        ext_trig[2] = 1'b0;
        settle();
    endtask

    task automatic t_capture();
        int c;
        m_ca = 24'h4;                     // trigger 1 rising
        m_cb = 24'h1 << 20;               // internal line 4
        ext_trig[1] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        c = count;
        cycles(1);
        chk("R6 cap_a value", cap_a, c);
        chk("R6 cap_a flag", fa, 1);
        chk("R6 count moves on", count, (c + 1) % 256);
        cycles(1);
        chk("R6 cap_a flag one cycle", fa, 0);
        int_evt[4] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        c = count;
        cycles(1);
        chk("R6 cap_b value", cap_b, c);
        chk("R6 cap_b flag", fb, 1);
        cycles(1);
        chk("R6 cap_b flag one cycle", fb, 0);
        ext_trig[1] = 1'b0; int_evt[4] = 1'b0;
        settle();
    endtask

    task automatic t_wrap();
        ext_trig[2] = 1'b1;
        settle();
        chk("R3 clear before wrap", count, 0);
        cycles(255);
        chk("R4 all ones", count, 255);
        cycles(1);
        chk("R4 wrap to zero", count, 0);
        ext_trig[2] = 1'b0;
        settle();
    endtask

    task automatic t_stop();
        int c;
        ext_trig[0] = 1'b0;               // bit 1 falling -> stop
        settle();
        chk("R7 R2 stopped", running, 0);
        c = count;
        cycles(4);
        chk("R2 frozen when stopped", count, c);
    endtask

    task automatic t_priority();
        m_start = 24'h41; m_stop = 24'h42;
        ext_trig[3] = 1'b1;               // bit 6 in both masks
        settle();
        chk("R2 stop beats start", running, 0);
        ext_trig[3] = 1'b0;
        settle();
        m_start = 24'h1; m_stop = 24'h2;
    endtask

    task automatic step_pin(input bit is_a, input bit lvl, input int exp, input string req);
        if (is_a) pin_a = lvl; else pin_b = lvl;
        settle();
        chk(req, count, exp);
    endtask

    task automatic t_quadrature();
        // up: 8,11,13,14  down: 9,10,12,15
        m_up = 24'h6900; m_dn = 24'h9600;
        ext_trig[0] = 1'b1;               // start
        settle();
        chk("R2 restart", running, 1);
        ext_trig[2] = 1'b1;               // clear
        settle();
        chk("R3 clear in event mode", count, 0);
        ext_trig[2] = 1'b0;
        settle();
        chk("R5 no step without event", count, 0);
        step_pin(1, 1, 1, "R8 A rise B low");
        step_pin(0, 1, 2, "R9 B rise A high");
        step_pin(1, 0, 3, "R8 A fall B high");
        step_pin(0, 0, 4, "R9 B fall A low");
        step_pin(0, 1, 3, "R9 B rise A low");
        step_pin(1, 1, 2, "R8 A rise B high");
        step_pin(0, 0, 1, "R9 B fall A high");
        step_pin(1, 0, 0, "R8 A fall B low");
    endtask

    task automatic t_cancel();
        m_up = 24'h1 << 16; m_dn = 24'h1 << 17;
        int_evt[1:0] = 2'b11;
        settle();
        chk("R5 up and down cancel", count, 0);
        int_evt[1:0] = 2'b00;
        settle();
        chk("R10 falling line no event", count, 0);
        int_evt[0] = 1'b1;
        settle();
        chk("R10 R5 up step", count, 1);
        int_evt[0] = 1'b0;
        int_evt[1] = 1'b1;
        settle();
        chk("R10 R5 down step", count, 0);
        int_evt[1] = 1'b0;
        ext_trig[0] = 1'b0;               // stop
        settle();
        int_evt[0] = 1'b1;
        settle();
        chk("R5 no step when stopped", count, 0);
        int_evt[0] = 1'b0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cycles(2);
        t_ignored();
        t_start_latency();
        t_clear_running();
        t_capture();
        t_wrap();
        t_stop();
        t_priority();
        t_quadrature();
        t_cancel();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule